// File: doc/BRIEF.md
# RGB Panel Sync Timing Generator

This block produces the horizontal sync, vertical sync and data-enable lines for a parallel RGB panel. It does so from a static set of geometry inputs: line length, active width and the lead-in before the active pixels, plus the same three values for the frame in lines. It also takes the start position and width of the horizontal pulse and the width of the vertical pulse. A pixel-request strobe marks every cycle in which the panel expects a pixel. A one-cycle event marks the start of every frame so that an interrupt can be raised.

The geometry inputs must stay constant while the generator runs. Rising `enable` restarts the count at the top-left corner of a frame. In single-shot mode the block paints one frame, pulses `frame_done` and then idles until `enable` rises again. In continuous mode frames follow each other with no gap. Each sync line has its own idle level, and its active level is the inverse of that idle level. The pixel-request strobe is a plain timing output with no back-pressure: the panel timing cannot stall, so whatever feeds pixels must already hold the next pixel when the strobe is high.

All outputs come from one register stage. The value seen after a rising edge reflects the counter position held before that edge. The first frame position therefore appears after the second rising edge that samples `enable` high.

Top module: `rgb_sync_timer`

## Requirements
- R1: While in reset, and while the generator is not running, `hsync`, `vsync` and `de` equal `hs_idle`, `vs_idle` and `de_idle`, and `pix_req`, `vs_event` and `frame_done` are 0.
- R2: A line lasts `h_total` cycles, with horizontal position 0 to `h_total`-1. On an active line, the horizontal active window covers positions `h_front` to `h_front`+`h_active`-1.
- R3: A frame lasts `v_total` lines, and the active lines are lines `v_front` to `v_front`+`v_active`-1. DE is active only where both the horizontal and the vertical windows are active.
- R4: The active level of `de` is the inverse of `de_idle`. `pix_req` is 1 exactly in the cycles where `de` is at its active level.
- R5: `hsync` takes the level inverse to `hs_idle` at horizontal positions `hs_pos` to `hs_pos`+`hs_width`-1.
- R6: With `hs_on_blank`=0, `hsync` pulses only on active lines. With `hs_on_blank`=1, it pulses on every line of the frame.
- R7: `vsync` takes the level inverse to `vs_idle` during the first `vs_width` lines of each frame.
- R8: `vs_event` is a one-cycle pulse at position (0,0) of every frame.
- R9: With `continuous`=0, `frame_done` pulses for one cycle at the last position of the frame. After that all outputs stay idle while `enable` remains high.
- R10: With `continuous`=1, the next frame follows the last position directly, starting with `vs_event`, and `frame_done` stays 0.
- R11: A rise of `enable` restarts at frame position (0,0), which appears after the second rising edge that samples `enable` high, even in the middle of a frame. Outputs are idle from the second rising edge that samples `enable` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| enable | input | 1 | Run request; a rising edge restarts the frame |
| h_total | input | 12 | Cycles per line |
| h_active | input | 12 | Active pixels per line |
| h_front | input | 11 | Cycles before the active pixels in a line |
| v_total | input | 10 | Lines per frame |
| v_active | input | 10 | Active lines per frame |
| v_front | input | 8 | Lines before the first active line |
| hs_pos | input | 8 | First horizontal position of the horizontal pulse |
| hs_width | input | 7 | Horizontal pulse width in cycles |
| vs_width | input | 7 | Vertical pulse width in lines |
| hs_idle | input | 1 | Idle level of hsync |
| vs_idle | input | 1 | Idle level of vsync |
| de_idle | input | 1 | Idle level of de |
| hs_on_blank | input | 1 | Also pulse hsync on blanking lines |
| continuous | input | 1 | Run frames back to back |
| hsync | output | 1 | Horizontal sync |
| vsync | output | 1 | Vertical sync |
| de | output | 1 | Data enable |
| pix_req | output | 1 | Pixel request strobe, active high |
| vs_event | output | 1 | Frame-start event pulse |
| frame_done | output | 1 | End of a single-shot frame |

## Verification
The hardest situation to reach from the ports is a restart in the middle of a frame. The counters must return to the corner even though the run flag never drops for long. The stimulus lowers `enable` for exactly one edge about a third of the way into a frame, raises it again, and then compares a full frame from position (0,0). A second hard case is the seam between two continuous frames, where the wrap must produce `vs_event` with no `frame_done`. The bench covers it by checking two whole frames without a gap.

// File: rtl/rgb_sync_pkg.sv
package rgb_sync_pkg;
  localparam int unsigned HCNT_W = 12;
  localparam int unsigned VCNT_W = 10;
  localparam int unsigned HFP_W  = 11;
  localparam int unsigned VFP_W  = 8;
  localparam int unsigned PULSE_W = 7;
  localparam int unsigned HPOS_W = 8;

  typedef struct packed {
    logic hs;
    logic vs;
    logic de;
    logic vse;
    logic fd;
  } sync_flags_t;
endpackage

// File: rtl/rgb_sync_window.sv
module rgb_sync_window #(
  parameter int unsigned W = 12
) (
  input  logic [W-1:0] pos,
  input  logic [W-1:0] start,
  input  logic [W-1:0] len,
  output logic         hit
);
  localparam int unsigned XW = W + 1;
  logic [XW-1:0] pos_x, lo_x, hi_x;

  always_comb begin
    pos_x = {1'b0, pos};
    lo_x  = {1'b0, start};
    hi_x  = lo_x + {1'b0, len};
    hit   = (pos_x >= lo_x) && (pos_x < hi_x);
  end
endmodule

// File: rtl/rgb_sync_counter.sv
module rgb_sync_counter #(
  parameter int unsigned HW = 12,
  parameter int unsigned VW = 10
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          enable,
  input  logic          continuous,
  input  logic [HW-1:0] h_total,
  input  logic [VW-1:0] v_total,
  output logic          running,
  output logic [HW-1:0] hcnt,
  output logic [VW-1:0] vcnt,
  output logic          at_start,
  output logic          at_last
);
  logic en_q;
  logic en_rise;
  logic h_end, v_end;

  always_comb begin
    en_rise  = enable & ~en_q;
    h_end    = (hcnt == h_total - HW'(1));
    v_end    = (vcnt == v_total - VW'(1));
    at_start = running && (hcnt == '0) && (vcnt == '0);
    at_last  = running && h_end && v_end;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q    <= 1'b0;
      running <= 1'b0;
      hcnt    <= '0;
      vcnt    <= '0;
    end else begin
      en_q <= enable;
      if (en_rise) begin
        running <= 1'b1;
        hcnt    <= '0;
        vcnt    <= '0;
      end else if (!enable) begin
        running <= 1'b0;
      end else if (running) begin
        if (h_end) begin
          hcnt <= '0;
          if (v_end) begin
            vcnt <= '0;
            if (!continuous) running <= 1'b0;
          end else begin
            vcnt <= vcnt + VW'(1);
          end
        end else begin
          hcnt <= hcnt + HW'(1);
        end
      end
    end
  end

  // R2: the horizontal position never leaves the line
  p_hcnt_in_line_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (running && h_total != '0) |-> (hcnt < h_total));
endmodule

// File: rtl/rgb_sync_timer.sv
module rgb_sync_timer
  import rgb_sync_pkg::*;
#(
  parameter int unsigned H_W   = HCNT_W,
  parameter int unsigned V_W   = VCNT_W,
  parameter int unsigned HF_W  = HFP_W,
  parameter int unsigned VF_W  = VFP_W,
  parameter int unsigned PW_W  = PULSE_W,
  parameter int unsigned HP_W  = HPOS_W
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            enable,
  input  logic [H_W-1:0]  h_total,
  input  logic [H_W-1:0]  h_active,
  input  logic [HF_W-1:0] h_front,
  input  logic [V_W-1:0]  v_total,
  input  logic [V_W-1:0]  v_active,
  input  logic [VF_W-1:0] v_front,
  input  logic [HP_W-1:0] hs_pos,
  input  logic [PW_W-1:0] hs_width,
  input  logic [PW_W-1:0] vs_width,
  input  logic            hs_idle,
  input  logic            vs_idle,
  input  logic            de_idle,
  input  logic            hs_on_blank,
  input  logic            continuous,
  output logic            hsync,
  output logic            vsync,
  output logic            de,
  output logic            pix_req,
  output logic            vs_event,
  output logic            frame_done
);
  logic           running, at_start, at_last;
  logic [H_W-1:0] hcnt;
  logic [V_W-1:0] vcnt;
  logic           h_act, v_act, hs_win, vs_win;
  sync_flags_t    nxt, q;

  rgb_sync_counter #(.HW(H_W), .VW(V_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .enable(enable), .continuous(continuous),
    .h_total(h_total), .v_total(v_total), .running(running),
    .hcnt(hcnt), .vcnt(vcnt), .at_start(at_start), .at_last(at_last)
  );

  rgb_sync_window #(.W(H_W)) u_h_act (
    .pos(hcnt), .start(H_W'(h_front)), .len(h_active), .hit(h_act));
  rgb_sync_window #(.W(V_W)) u_v_act (
    .pos(vcnt), .start(V_W'(v_front)), .len(v_active), .hit(v_act));
  rgb_sync_window #(.W(H_W)) u_hs (
    .pos(hcnt), .start(H_W'(hs_pos)), .len(H_W'(hs_width)), .hit(hs_win));
  rgb_sync_window #(.W(V_W)) u_vs (
    .pos(vcnt), .start('0), .len(V_W'(vs_width)), .hit(vs_win));

  always_comb begin
    nxt.hs  = running && hs_win && (v_act || hs_on_blank);
    nxt.vs  = running && vs_win;
    nxt.de  = running && h_act && v_act;
    nxt.vse = at_start;
    nxt.fd  = at_last && !continuous;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= '0;
    else        q <= nxt;
  end

  // active level is the inverse of the idle level
  assign hsync      = hs_idle ^ q.hs;
  assign vsync      = vs_idle ^ q.vs;
  assign de         = de_idle ^ q.de;
  assign pix_req    = q.de;
  assign vs_event   = q.vse;
  assign frame_done = q.fd;

  // R9: a finished single-shot frame leaves every line idle
  p_idle_after_done_r9: assert property (@(posedge clk) disable iff (!rst_n)
    frame_done |=> (hsync == hs_idle && vsync == vs_idle && de == de_idle && !vs_event));

  // R11: disabled for three sampled edges means idle outputs
  p_idle_when_off_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (!enable && !$past(enable) && !$past(enable, 2)) |->
      (hsync == hs_idle && vsync == vs_idle && !pix_req && !frame_done));

  // R8: the frame-start event falls inside the vertical pulse
  p_vs_event_in_sync_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (vs_event && vs_width != '0) |-> (vsync != vs_idle));
endmodule

// File: tb/rgb_sync_timer_tb.sv
`timescale 1ns/1ps
module rgb_sync_timer_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic enable = 1'b0;
  logic [11:0] h_total, h_active;
  logic [10:0] h_front;
  logic [9:0]  v_total, v_active;
  logic [7:0]  v_front, hs_pos;
  logic [6:0]  hs_width, vs_width;
  logic hs_idle, vs_idle, de_idle, hs_on_blank, continuous;
  logic hsync, vsync, de, pix_req, vs_event, frame_done;

  int checks = 0;
  int fails = 0;

  always #4 clk = ~clk;

  rgb_sync_timer u_dut (
    .clk(clk), .rst_n(rst_n), .enable(enable),
    .h_total(h_total), .h_active(h_active), .h_front(h_front),
    .v_total(v_total), .v_active(v_active), .v_front(v_front),
    .hs_pos(hs_pos), .hs_width(hs_width), .vs_width(vs_width),
    .hs_idle(hs_idle), .vs_idle(vs_idle), .de_idle(de_idle),
    .hs_on_blank(hs_on_blank), .continuous(continuous),
    .hsync(hsync), .vsync(vsync), .de(de), .pix_req(pix_req),
    .vs_event(vs_event), .frame_done(frame_done)
  );

  task automatic check(input string req, input string what, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%b expected=%b t=%0t", req, what, act, exp, $time);
    end
  endtask

  task automatic check_idle(input string req);
    check(req, "hsync idle", hsync, hs_idle);
    check(req, "vsync idle", vsync, vs_idle);
    check(req, "de idle", de, de_idle);
    check(req, "pix_req low", pix_req, 1'b0);
    check(req, "vs_event low", vs_event, 1'b0);
    check(req, "frame_done low", frame_done, 1'b0);
  endtask

  task automatic set_geom(input logic hi, input logic vi, input logic di, input logic blank, input logic cont);
    h_total = 12; h_active = 6; h_front = 3;
    v_total = 6;  v_active = 3; v_front = 1;
    hs_pos = 1; hs_width = 2; vs_width = 1;
    hs_idle = hi; vs_idle = vi; de_idle = di;
    hs_on_blank = blank; continuous = cont;
  endtask

  // compare every position of nfr frames, starting from an enable rise
  task automatic run_frames(input int nfr, input string tag);
    enable = 1'b1;
    @(posedge clk);
    for (int fr = 0; fr < nfr; fr++)
      for (int v = 0; v < int'(v_total); v++)
        for (int h = 0; h < int'(h_total); h++) begin
          logic ha, va, e_hs, e_vs, e_de, e_vse, e_fd;
          @(posedge clk); @(negedge clk);
          ha = (h >= int'(h_front)) && (h < int'(h_front) + int'(h_active));
          va = (v >= int'(v_front)) && (v < int'(v_front) + int'(v_active));
          e_de = ha && va;
          e_hs = (h >= int'(hs_pos)) && (h < int'(hs_pos) + int'(hs_width)) && (va || hs_on_blank);
          e_vs = v < int'(vs_width);
          e_vse = (h == 0) && (v == 0);
          e_fd = !continuous && (h == int'(h_total) - 1) && (v == int'(v_total) - 1);
          check({tag, "/R5"}, "hsync", hsync, e_hs ? ~hs_idle : hs_idle);
          check({tag, "/R7"}, "vsync", vsync, e_vs ? ~vs_idle : vs_idle);
          check({tag, "/R3"}, "de", de, e_de ? ~de_idle : de_idle);
          check({tag, "/R4"}, "pix_req", pix_req, e_de);
          check({tag, "/R8"}, "vs_event", vs_event, e_vse);
          check({tag, "/R9"}, "frame_done", frame_done, e_fd);
        end
  endtask

  task automatic go_idle();
    @(negedge clk); enable = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic t_reset();
    set_geom(1'b1, 1'b0, 1'b1, 1'b0, 1'b0);
    repeat (3) @(posedge clk);
    @(negedge clk);
    check_idle("R1");
    rst_n = 1'b1;
    repeat (2) @(posedge clk);
    @(negedge clk);
    check_idle("R1");
  endtask

  task automatic t_single_frame();
    set_geom(1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
    @(negedge clk);
    run_frames(1, "R2");
    for (int i = 0; i < 10; i++) begin
      @(posedge clk); @(negedge clk);
      check_idle("R9");
    end
    go_idle();
  endtask

  task automatic t_inverted_blank();
    set_geom(1'b1, 1'b1, 1'b1, 1'b1, 1'b0);
    @(negedge clk);
    run_frames(1, "R6");
    @(posedge clk); @(negedge clk);
    check_idle("R6");
    go_idle();
  endtask

  task automatic t_continuous();
    set_geom(1'b0, 1'b1, 1'b0, 1'b0, 1'b1);
    @(negedge clk);
    run_frames(2, "R10");
    @(negedge clk); enable = 1'b0;
    @(posedge clk); @(posedge clk); @(negedge clk);
    check_idle("R11");
    go_idle();
  endtask

  task automatic t_restart();
    set_geom(1'b0, 1'b0, 1'b1, 1'b1, 1'b0);
    @(negedge clk);
    enable = 1'b1;
    repeat (25) @(posedge clk);
    @(negedge clk); enable = 1'b0;
    @(posedge clk);
    @(negedge clk);
    run_frames(1, "R11");
    go_idle();
  endtask

  initial begin
    t_reset();
    t_single_frame();
    t_inverted_blank();
    t_continuous();
    t_restart();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule